// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects sixteen level-sensitive interrupt sources and reports to the CPU the single request that should be served next. Each source gets its 4-bit priority from a programmable field. Some fields are shared, so that one value sets the level of a whole family of related sources: a three-member timer family and a four-member serial family each take their level from one field. Every source also has a mask bit. The mask bits are changed through two write addresses, one that sets bits and one that clears them, so that software never has to do a read-modify-write.

Every clock the controller looks at the pending sources that are unmasked and have a non-zero level. It registers a request flag, the winning level and the winner's event code. The event code for source index n is 0x400 + 0x20·n, so the CPU can use it directly as a dispatch offset.

Top module: `grp_intc`

## Requirements
- R1: After reset every priority field is 0, the mask read-back is 0x0000FFFF (all sixteen sources masked) and the irq_req, irq_level and irq_code outputs are 0.
- R2: Addresses 0 and 1 are 16-bit priority registers that hold fields 0–3 and 4–7. Within a register the lowest-numbered field sits in bits 15:12, the next in bits 11:8, and so on down to bits 3:0. Bits 31:16 read as 0.
- R3: Address 2 is a 32-bit priority register whose nibble j sits in bits (31−4j):(28−4j). Only nibbles 0–2 are stored, as fields 8–10. The other nibbles ignore writes and read as 0.
- R4: Sources 0–2 share field 0 and sources 3–6 share field 1. Source s in 7–15 uses field s−5.
- R5: Writing to address 3 sets the mask bit of every source whose wdata bit is 1. Zero bits leave their mask bit unchanged. Reading address 3 returns the mask in bits 15:0.
- R6: Writing to address 4 clears the mask bit of every source whose wdata bit is 1. Zero bits leave their mask bit unchanged.
- R7: A source whose field is 0 never produces a request, even when it is pending and unmasked.
- R8: Among pending, unmasked sources with a non-zero level, the highest level wins. On equal levels the lower source index wins.
- R9: While irq_req is 1, irq_level is the winner's level and irq_code is 0x400 + 0x20·index. While irq_req is 0, both are 0.
- R10: The outputs follow a change of src_i at the next rising edge, and a register write one edge after the write is taken. If src_i and the registers are unchanged, the outputs hold.
- R11: Writes to addresses 5–7 change no register, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Level-sensitive interrupt sources, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_req | output | 1 | A request is presented |
| irq_level | output | 4 | Level of the winning source |
| irq_code | output | 12 | Event code of the winning source |

## Verification
Some properties are checked on every clock:
- the per-bit effect of set and clear writes on the mask;
- that writes to unused addresses leave all state unchanged;
- that a request always carries a non-zero level and a 0x20-aligned code;
- that the winner is an eligible source;
- that the outputs hold while sources and registers are quiet.

Other behaviour only the bench scenarios can show:
- the field packing of each priority register;
- the group mapping;
- that a zero field disables its sources;
- tie-breaking by index;
- the exact one-edge and two-edge latencies.

For these the bench compares the outputs with its own arbitration model.

// File: rtl/grp_intc_pkg.sv
package grp_intc_pkg;
  localparam int NUM_SRC     = 16;
  localparam int LVL_W       = 4;
  localparam int CODE_W      = 12;
  localparam int ADDR_W      = 3;
  localparam int DATA_W      = 32;
  localparam int NARROW_W    = 16;
  localparam int NARROW_FLD  = 4;
  localparam int NUM_NARROW  = 2;
  localparam int WIDE_USED   = 3;
  localparam int WIDE_BASE   = NUM_NARROW * NARROW_FLD;
  localparam int NUM_FIELD   = WIDE_BASE + WIDE_USED;
  localparam int IDX_W       = $clog2(NUM_SRC);

  localparam logic [CODE_W-1:0] CODE_BASE = 12'h400;
  localparam logic [CODE_W-1:0] CODE_STEP = 12'h020;

  localparam logic [ADDR_W-1:0] A_PRI_A = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRI_B = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRI_W = 3'd2;
  localparam logic [ADDR_W-1:0] A_MSET  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCLR  = 3'd4;

  // Group map: timer family 0..2 -> field 0, serial family 3..6 -> field 1,
  // every later source owns one field.
  function automatic int field_of(input int s);
    if (s < 3) return 0;
    else if (s < 7) return 1;
    else return s - 5;
  endfunction

  function automatic logic [CODE_W-1:0] code_of(input logic [IDX_W-1:0] idx);
    return CODE_BASE + CODE_W'(idx) * CODE_STEP;
  endfunction
endpackage

// File: rtl/grp_intc_regs.sv
module grp_intc_regs
  import grp_intc_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wdata,
  output logic [DATA_W-1:0]                   rdata,
  output logic [NUM_FIELD-1:0][LVL_W-1:0]     field_lvl,
  output logic [NUM_SRC-1:0]                  mask
);
  logic [NUM_FIELD-1:0][LVL_W-1:0] fld_q;
  logic [NUM_SRC-1:0]              mask_q;
  logic [NUM_SRC-1:0]              wbits;

  assign wbits = wdata[NUM_SRC-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      for (int r = 0; r < NUM_NARROW; r++) begin
        if (addr == ADDR_W'(r)) begin
          for (int k = 0; k < NARROW_FLD; k++)
            fld_q[r*NARROW_FLD+k] <= wdata[NARROW_W-1-LVL_W*k -: LVL_W];
        end
      end
      if (addr == A_PRI_W) begin
        for (int j = 0; j < WIDE_USED; j++)
          fld_q[WIDE_BASE+j] <= wdata[DATA_W-1-LVL_W*j -: LVL_W];
      end
      if (addr == A_MSET) mask_q <= mask_q | wbits;
      if (addr == A_MCLR) mask_q <= mask_q & ~wbits;
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_NARROW; r++) begin
      if (addr == ADDR_W'(r)) begin
        for (int k = 0; k < NARROW_FLD; k++)
          rdata[NARROW_W-1-LVL_W*k -: LVL_W] = fld_q[r*NARROW_FLD+k];
      end
    end
    if (addr == A_PRI_W) begin
      for (int j = 0; j < WIDE_USED; j++)
        rdata[DATA_W-1-LVL_W*j -: LVL_W] = fld_q[WIDE_BASE+j];
    end
    if (addr == A_MSET || addr == A_MCLR) rdata[NUM_SRC-1:0] = mask_q;
  end

  assign field_lvl = fld_q;
  assign mask      = mask_q;

  AST_MSET_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MSET) |=> ((mask_q & $past(wbits)) == $past(wbits))); // R5
  AST_MSET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MSET) |=> ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits)))); // R5
  AST_MCLR_UNMASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MCLR) |=> ((mask_q & $past(wbits)) == '0)); // R6
  AST_MCLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MCLR) |=> ((mask_q | $past(wbits)) == ($past(mask_q) | $past(wbits)))); // R6
  AST_UNUSED_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > A_MCLR) |=> ($stable(mask_q) && $stable(fld_q))); // R11
endmodule

// File: rtl/grp_intc_arb.sv
module grp_intc_arb
  import grp_intc_pkg::*;
(
  input  logic [NUM_SRC-1:0]              src,
  input  logic [NUM_SRC-1:0]              mask,
  input  logic [NUM_FIELD-1:0][LVL_W-1:0] field_lvl,
  output logic [NUM_SRC-1:0]              eligible,
  output logic                            hit,
  output logic [LVL_W-1:0]                win_lvl,
  output logic [IDX_W-1:0]                win_idx
);
  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign src_lvl[s]  = field_lvl[field_of(s)];
    assign eligible[s] = src[s] && !mask[s] && (src_lvl[s] != '0);
  end

  // Strictly-greater replacement keeps the lowest index on a tie.
  always_comb begin
    hit     = 1'b0;
    win_lvl = '0;
    win_idx = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (eligible[s] && src_lvl[s] > win_lvl) begin
        hit     = 1'b1;
        win_lvl = src_lvl[s];
        win_idx = IDX_W'(s);
      end
    end
  end
endmodule

// File: rtl/grp_intc.sv
module grp_intc
  import grp_intc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                irq_req,
  output logic [LVL_W-1:0]    irq_level,
  output logic [CODE_W-1:0]   irq_code
);
  logic [NUM_FIELD-1:0][LVL_W-1:0] field_lvl;
  logic [NUM_SRC-1:0]              mask;
  logic [NUM_SRC-1:0]              eligible;
  logic                            hit;
  logic [LVL_W-1:0]                win_lvl;
  logic [IDX_W-1:0]                win_idx;

  grp_intc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .field_lvl(field_lvl), .mask(mask)
  );

  grp_intc_arb u_arb (
    .src(src_i), .mask(mask), .field_lvl(field_lvl), .eligible(eligible),
    .hit(hit), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
      irq_code  <= '0;
    end else begin
      irq_req   <= hit;
      irq_level <= hit ? win_lvl : '0;
      irq_code  <= hit ? code_of(win_idx) : '0;
    end
  end

  AST_REQ_HAS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level != '0)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_level == '0 && irq_code == '0)); // R9
  AST_CODE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_code[4:0] == 5'd0 && irq_code >= CODE_BASE)); // R9
  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> eligible[win_idx]); // R8
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(src_i) && !$past(wr_en)) |=>
      ($stable(irq_req) && $stable(irq_level) && $stable(irq_code))); // R10
endmodule

// File: tb/grp_intc_bench.sv
module grp_intc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_req;
  logic [3:0]  irq_level;
  logic [11:0] irq_code;

  grp_intc u_grp_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_req(irq_req), .irq_level(irq_level),
    .irq_code(irq_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        req;
    logic [3:0]  lvl;
    logic [11:0] code;
    string       tag;
  } exp_t;

  exp_t   sbq[$];
  int     checks = 0;
  int     errors = 0;
  logic [3:0]  m_fld [0:10];
  logic [15:0] m_mask;

  // Bench view of the group map (R4).
  function automatic int m_field(input int s);
    case (s)
      0, 1, 2:    return 0;
      3, 4, 5, 6: return 1;
      default:    return s - 5;
    endcase
  endfunction

  // Search levels from the top, and within a level the indices from the bottom.
  function automatic exp_t model(input string tag);
    exp_t e;
    e.req = 0; e.lvl = 0; e.code = 0; e.tag = tag;
    for (int l = 15; l >= 1; l--) begin
      for (int s = 0; s < 16; s++) begin
        if (!e.req && src_i[s] && !m_mask[s] && m_fld[m_field(s)] == 4'(l)) begin
          e.req = 1; e.lvl = 4'(l); e.code = 12'h400 + 12'(s * 32);
        end
      end
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic expect_out(input string tag);
    @(posedge clk);
    sbq.push_back(model(tag));
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      3'd0: for (int k = 0; k < 4; k++) m_fld[k]   = d[15-4*k -: 4];
      3'd1: for (int k = 0; k < 4; k++) m_fld[4+k] = d[15-4*k -: 4];
      3'd2: for (int j = 0; j < 3; j++) m_fld[8+j] = d[31-4*j -: 4];
      3'd3: m_mask = m_mask | d[15:0];
      3'd4: m_mask = m_mask & ~d[15:0];
      default: ;
    endcase
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic set_src(input logic [15:0] v);
    @(negedge clk);
    src_i = v;
  endtask

  // Monitor: pop one expected item per falling edge and compare with the outputs.
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (irq_req !== e.req || irq_level !== e.lvl || irq_code !== e.code) begin
          errors++;
          $display("FAIL %s got req=%b lvl=%h code=%h expected req=%b lvl=%h code=%h",
                   e.tag, irq_req, irq_level, irq_code, e.req, e.lvl, e.code);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 11; i++) m_fld[i] = 0;
    m_mask = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    rd_check(3'd0, 32'h0, "R1 prio A after reset");
    rd_check(3'd3, 32'h0000FFFF, "R1 mask after reset");
    expect_out("R1 idle after reset");

    // R2: narrow register packing; masked source stays silent
    reg_write(3'd0, 32'hABCD_5300);
    rd_check(3'd0, 32'h0000_5300, "R2 prio A readback");
    set_src(16'h0002);
    expect_out("R1 masked source silent");

    // R6: unmask everything
    reg_write(3'd4, 32'h0000_FFFF);
    rd_check(3'd4, 32'h0, "R6 mask cleared");
    expect_out("R4 R9 timer member 1 code 0x420");
    set_src(16'h0012);
    expect_out("R8 higher level wins over serial family");
    set_src(16'h0010);
    expect_out("R4 serial member level 3 code 0x480");
    set_src(16'h0005);
    expect_out("R8 tie lower index wins");

    // R5: set-mask and zero write
    reg_write(3'd3, 32'h0000_0001);
    rd_check(3'd3, 32'h0000_0001, "R5 mask bit0 set");
    expect_out("R5 masked src0 yields src2");
    reg_write(3'd3, 32'h0);
    rd_check(3'd3, 32'h0000_0001, "R5 zero write no effect");
    reg_write(3'd4, 32'h0);
    rd_check(3'd4, 32'h0000_0001, "R6 zero write no effect");

    // R3: wide register
    reg_write(3'd2, 32'hF07A_BCDE);
    rd_check(3'd2, 32'hF070_0000, "R3 wide readback reserved zero");
    set_src(16'h2000);
    expect_out("R3 src13 level F code 0x5A0");
    set_src(16'h4000);
    expect_out("R7 zero field disables src14");
    set_src(16'hC000);
    expect_out("R3 src15 level 7");
    set_src(16'hE005);
    expect_out("R8 wide field level F wins");

    // R2 second narrow register; R7 src7 field zero
    reg_write(3'd1, 32'h0000_1234);
    rd_check(3'd1, 32'h0000_1234, "R2 prio B readback");
    set_src(16'h1080);
    expect_out("R7 src7 disabled src12 level 4");

    // R11: unused addresses
    reg_write(3'd5, 32'hFFFF_FFFF);
    reg_write(3'd7, 32'hFFFF_FFFF);
    rd_check(3'd5, 32'h0, "R11 unused reads zero");
    rd_check(3'd0, 32'h0000_5300, "R11 prio A unchanged");
    rd_check(3'd3, 32'h0000_0001, "R11 mask unchanged");
    expect_out("R11 output unchanged");

    // R10: register write latency (two edges)
    @(negedge clk);
    wr_en = 1; addr = 3'd0; wdata = 32'h0000_5390;
    @(posedge clk); #1;
    check("R10 old level after write edge", {28'h0, irq_level}, 32'h4);
    @(negedge clk);
    wr_en = 0;
    m_fld[2] = 4'h9;
    expect_out("R10 new level after second edge");

    // R10: source latency (one edge)
    @(negedge clk);
    src_i = 16'h0040;
    #1;
    check("R10 output holds before edge", {20'h0, irq_code}, 32'h4E0);
    expect_out("R10 source change after one edge");
    expect_out("R10 quiet hold");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule